// File: doc/BRIEF.md
# Split-Word Host/Function Mailbox Bank

This block holds one 32-bit mailbox word for each virtual function. A single host port can read and write any word. Each function has its own port, and that port is wired only to the word at its own index. Each word has two halves that carry traffic in opposite directions. The lower half carries messages from the host to the function. The upper half carries messages from the function to the host.

A sender posts a message by writing its half with the interrupt bit set. That bit is the lowest bit of the half. The stored bit drives an interrupt line toward the other side. The receiver acknowledges by writing the same half with the interrupt bit clear, and this drops the line. Before posting, a sender may write an in-use marker into the opposite half as a collision guard. Such a write is stored as written.

Each half is also decoded into three fields for the receiving side: a valid flag, a 4-bit message type and 10 bits of message data. The valid flag is raised only when the origin flag is set. A half whose origin flag is zero raises its interrupt but never reports a valid message.

Top module: `mbx_bank`

## Requirements
- R1: After a synchronous active-low reset, every word is zero, all interrupt outputs are low and all decoded valid flags are low.
- R2: A host write to index i updates bits 15:0 of word i when host_be[0] is 1 and bits 31:16 when host_be[1] is 1. A half whose enable is 0 is unchanged. Other words are unchanged, and a write with both enables at 0 changes nothing.
- R3: Function port i writes only word i, using fn_be[2i] for bits 15:0 and fn_be[2i+1] for bits 31:16. Data on a port whose fn_we bit is low changes no word.
- R4: fn_irq[i] follows bit 0 of word i and host_irq[i] follows bit 16 of word i. Each line changes in the cycle after the clock edge that stores the write, never before it.
- R5: Writing a half with its interrupt bit (bit 0 or bit 16) at 0 drops the matching interrupt output in the next cycle.
- R6: to_fn_valid[i] is 1 only when bits 0 and 1 of word i are both 1. to_host_valid[i] is 1 only when bits 16 and 17 are both 1. An origin bit of 0 gives no valid flag, even while the interrupt is high.
- R7: For each word, the lower-half type is bits 5:2 and the lower-half data is bits 15:6. The upper-half type is bits 21:18 and the upper-half data is bits 31:22.
- R8: A write with the interrupt bit of the written half at 0, such as an in-use marker, is stored unchanged and raises no interrupt.
- R9: In one cycle, a host write to the lower half of word i and a write by function i to the upper half of word i both take effect.
- R10: When both sides write the same half in one cycle, the half's owner wins: the host for bits 15:0 and the function for bits 31:16.
- R11: host_rdata shows the word selected by host_idx in the same cycle. fn_rdata slice i always shows word i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_idx | input | IDX_W | Host word select, used for both write and read |
| host_be | input | 2 | Host half enables: bit 0 for the lower half, bit 1 for the upper half |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Word selected by host_idx |
| fn_we | input | NUM_FN | Per-function write strobes |
| fn_be | input | 2*NUM_FN | Per-function half enables, two bits per function |
| fn_wdata | input | 32*NUM_FN | Per-function write data, 32 bits per function |
| fn_rdata | output | 32*NUM_FN | Per-function view of its own word |
| fn_irq | output | NUM_FN | Interrupt toward each function |
| host_irq | output | NUM_FN | Interrupt toward the host, one bit per word |
| to_fn_valid | output | NUM_FN | A valid host-to-function message is pending |
| to_fn_type | output | 4*NUM_FN | Decoded host-to-function message type |
| to_fn_data | output | 10*NUM_FN | Decoded host-to-function message data |
| to_host_valid | output | NUM_FN | A valid function-to-host message is pending |
| to_host_type | output | 4*NUM_FN | Decoded function-to-host message type |
| to_host_data | output | 10*NUM_FN | Decoded function-to-host message data |

## Verification
The host and a function can write the same word in the same clock cycle. This happens in the normal protocol when one side posts into its own half while the other side acknowledges or marks the half it does not own. The bench provokes this in two ways. First, it drives both ports in one cycle on disjoint halves, and expects both values to land. Second, it drives both ports on the same half, lower and then upper, and expects the owner's data to survive while the other side's data is lost. In every case the word is judged through the function read port, the interrupt lines and the decoded fields at the falling edge after the storing edge.

// File: rtl/mbx_pkg.sv
// Shared constants and the decoded-message type for the mailbox bank.
// Assumes a 32-bit word made of two 16-bit halves with the same layout.
package mbx_pkg;
    localparam int WORD_W   = 32;
    localparam int HALF_W   = WORD_W / 2;
    localparam int INT_POS  = 0;
    localparam int ORG_POS  = 1;
    localparam int TYPE_LSB = 2;
    localparam int TYPE_W   = 4;
    localparam int DATA_LSB = TYPE_LSB + TYPE_W;
    localparam int DATA_W   = HALF_W - DATA_LSB;

    typedef struct packed {
        logic              valid;
        logic [TYPE_W-1:0] kind;
        logic [DATA_W-1:0] data;
    } msg_t;
endpackage

// File: rtl/mbx_half.sv
// One half of a mailbox word, with two writers and an owner-priority merge.
// Assumes the owner's write beats the other side's write in the same cycle.
module mbx_half #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         own_we,
    input  logic [W-1:0] own_d,
    input  logic         oth_we,
    input  logic [W-1:0] oth_d,
    output logic [W-1:0] q
);
    // Store the owner's write, else the other side's write, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (own_we)
            q <= own_d;
        else if (oth_we)
            q <= oth_d;
    end

    assert_owner_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (own_we && oth_we) |=> (q == $past(own_d)));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_we && !oth_we) |=> $stable(q));

    assert_ack_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((own_we && !own_d[0]) || (!own_we && oth_we && !oth_d[0])) |=> !q[0]);
endmodule

// File: rtl/mbx_decode.sv
// Splits one stored half into a valid flag, a type and data.
// Assumes valid needs both the interrupt bit and the origin flag set.
module mbx_decode
    import mbx_pkg::*;
(
    input  logic [HALF_W-1:0] half,
    output msg_t              msg
);
    // Extract the fields and qualify them with the origin flag.
    always_comb begin
        msg.valid = half[INT_POS] & half[ORG_POS];
        msg.kind  = half[TYPE_LSB +: TYPE_W];
        msg.data  = half[DATA_LSB +: DATA_W];
    end
endmodule

// File: rtl/mbx_entry.sv
// One mailbox word: the host owns the lower half and the function owns the upper.
// Assumes host_we is already qualified by the host's index match.
module mbx_entry
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [1:0]        host_be,
    input  logic [WORD_W-1:0] host_d,
    input  logic              fn_we,
    input  logic [1:0]        fn_be,
    input  logic [WORD_W-1:0] fn_d,
    output logic [WORD_W-1:0] word,
    output msg_t              lo_msg,
    output msg_t              hi_msg
);
    for (genvar h = 0; h < 2; h++) begin : g_half
        logic              own_we;
        logic              oth_we;
        logic [HALF_W-1:0] own_d;
        logic [HALF_W-1:0] oth_d;
        if (h == 0) begin : g_lo
            assign own_we = host_we & host_be[0];
            assign own_d  = host_d[HALF_W-1:0];
            assign oth_we = fn_we & fn_be[0];
            assign oth_d  = fn_d[HALF_W-1:0];
        end else begin : g_hi
            assign own_we = fn_we & fn_be[1];
            assign own_d  = fn_d[WORD_W-1:HALF_W];
            assign oth_we = host_we & host_be[1];
            assign oth_d  = host_d[WORD_W-1:HALF_W];
        end
        mbx_half #(.W(HALF_W)) u_half (
            .clk    (clk),
            .rst_n  (rst_n),
            .own_we (own_we),
            .own_d  (own_d),
            .oth_we (oth_we),
            .oth_d  (oth_d),
            .q      (word[h*HALF_W +: HALF_W])
        );
    end

    mbx_decode u_dec_lo (.half(word[HALF_W-1:0]),      .msg(lo_msg));
    mbx_decode u_dec_hi (.half(word[WORD_W-1:HALF_W]), .msg(hi_msg));

    assert_both_halves_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_be == 2'b01 && fn_we && fn_be == 2'b10)
        |=> (word == {$past(fn_d[WORD_W-1:HALF_W]), $past(host_d[HALF_W-1:0])}));

    assert_isolation_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_we && !fn_we) |=> $stable(word));
endmodule

// File: rtl/mbx_bank.sv
// Bank of split-direction mailbox words: one host port and one port per function.
// Assumes 1 <= NUM_FN <= 16; a host index at or above NUM_FN selects no word.
module mbx_bank
    import mbx_pkg::*;
#(
    parameter int NUM_FN = 4,
    localparam int IDX_W = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_we,
    input  logic [IDX_W-1:0]           host_idx,
    input  logic [1:0]                 host_be,
    input  logic [WORD_W-1:0]          host_wdata,
    output logic [WORD_W-1:0]          host_rdata,
    input  logic [NUM_FN-1:0]          fn_we,
    input  logic [2*NUM_FN-1:0]        fn_be,
    input  logic [WORD_W*NUM_FN-1:0]   fn_wdata,
    output logic [WORD_W*NUM_FN-1:0]   fn_rdata,
    output logic [NUM_FN-1:0]          fn_irq,
    output logic [NUM_FN-1:0]          host_irq,
    output logic [NUM_FN-1:0]          to_fn_valid,
    output logic [TYPE_W*NUM_FN-1:0]   to_fn_type,
    output logic [DATA_W*NUM_FN-1:0]   to_fn_data,
    output logic [NUM_FN-1:0]          to_host_valid,
    output logic [TYPE_W*NUM_FN-1:0]   to_host_type,
    output logic [DATA_W*NUM_FN-1:0]   to_host_data
);
    logic [WORD_W-1:0] words [NUM_FN];

    for (genvar i = 0; i < NUM_FN; i++) begin : g_ent
        logic host_sel;
        msg_t lo_msg;
        msg_t hi_msg;

        assign host_sel = host_we && (host_idx == IDX_W'(i));

        mbx_entry u_ent (
            .clk     (clk),
            .rst_n   (rst_n),
            .host_we (host_sel),
            .host_be (host_be),
            .host_d  (host_wdata),
            .fn_we   (fn_we[i]),
            .fn_be   (fn_be[2*i +: 2]),
            .fn_d    (fn_wdata[WORD_W*i +: WORD_W]),
            .word    (words[i]),
            .lo_msg  (lo_msg),
            .hi_msg  (hi_msg)
        );

        assign fn_rdata[WORD_W*i +: WORD_W] = words[i];
        assign fn_irq[i]                    = words[i][INT_POS];
        assign host_irq[i]                  = words[i][HALF_W + INT_POS];
        assign to_fn_valid[i]               = lo_msg.valid;
        assign to_fn_type[TYPE_W*i +: TYPE_W]   = lo_msg.kind;
        assign to_fn_data[DATA_W*i +: DATA_W]   = lo_msg.data;
        assign to_host_valid[i]             = hi_msg.valid;
        assign to_host_type[TYPE_W*i +: TYPE_W] = hi_msg.kind;
        assign to_host_data[DATA_W*i +: DATA_W] = hi_msg.data;
    end

    // Select the word addressed by the host index for the host read port.
    always_comb begin
        host_rdata = '0;
        for (int i = 0; i < NUM_FN; i++)
            if (host_idx == IDX_W'(i))
                host_rdata = words[i];
    end
endmodule

// File: tb/sim_mbx_bank.sv
`timescale 1ns/1ps
module sim_mbx_bank;
    localparam int N     = 4;
    localparam int IDX_W = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              host_we;
    logic [IDX_W-1:0]  host_idx;
    logic [1:0]        host_be;
    logic [31:0]       host_wdata;
    logic [31:0]       host_rdata;
    logic [N-1:0]      fn_we;
    logic [2*N-1:0]    fn_be;
    logic [32*N-1:0]   fn_wdata;
    logic [32*N-1:0]   fn_rdata;
    logic [N-1:0]      fn_irq, host_irq, to_fn_valid, to_host_valid;
    logic [4*N-1:0]    to_fn_type, to_host_type;
    logic [10*N-1:0]   to_fn_data, to_host_data;

    mbx_bank #(.NUM_FN(N)) u0 (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_idx(host_idx), .host_be(host_be),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .fn_we(fn_we), .fn_be(fn_be), .fn_wdata(fn_wdata), .fn_rdata(fn_rdata),
        .fn_irq(fn_irq), .host_irq(host_irq),
        .to_fn_valid(to_fn_valid), .to_fn_type(to_fn_type), .to_fn_data(to_fn_data),
        .to_host_valid(to_host_valid), .to_host_type(to_host_type),
        .to_host_data(to_host_data)
    );

    always #10 clk = ~clk;

    typedef struct {
        int          kind;
        int          idx;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t       sbq[$];
    logic [31:0] mdl [N];
    int          checks = 0;
    int          errors = 0;
    int          cycles = 0;

    task automatic push(input int kind, input int idx, input logic [31:0] exp, input string req);
        item_t it;
        it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
        sbq.push_back(it);
    endtask

    // Expected words, interrupt lines and valid flags, computed from the model.
    task automatic push_state(input string req);
        logic [31:0] fi, hi, fv, hv;
        fi = '0; hi = '0; fv = '0; hv = '0;
        for (int i = 0; i < N; i++) begin
            push(0, i, mdl[i], req);
            fi[i] = mdl[i][0];
            hi[i] = mdl[i][16];
            fv[i] = mdl[i][0] & mdl[i][1];
            hv[i] = mdl[i][16] & mdl[i][17];
        end
        push(1, 0, fi, req);
        push(2, 0, hi, req);
        push(3, 0, fv, req);
        push(4, 0, hv, req);
    endtask

    // Expected decoded type and data for both halves of one word.
    task automatic push_fields(input int i, input string req);
        push(6, i, 32'({mdl[i][5:2], mdl[i][15:6]}), req);
        push(7, i, 32'({mdl[i][21:18], mdl[i][31:22]}), req);
    endtask

    // Drive one cycle of writes and apply the owner-priority rule to the model.
    task automatic step(input logic h_en, input int h_idx, input logic [1:0] h_be,
                        input logic [31:0] h_wd, input logic [N-1:0] f_mask,
                        input logic [2*N-1:0] f_be, input logic [32*N-1:0] f_wd,
                        input bit pre, input string req);
        host_we = h_en; host_idx = IDX_W'(h_idx); host_be = h_be; host_wdata = h_wd;
        fn_we = f_mask; fn_be = f_be; fn_wdata = f_wd;
        if (pre) push_state({req, " before edge"});
        @(posedge clk);
        #1;
        host_we = 1'b0; fn_we = '0; host_be = '0; fn_be = '0;
        for (int i = 0; i < N; i++) begin
            logic hs, lo_h, lo_f, hi_h, hi_f;
            hs   = h_en && (h_idx == i);
            lo_h = hs && h_be[0];
            hi_h = hs && h_be[1];
            lo_f = f_mask[i] && f_be[2*i];
            hi_f = f_mask[i] && f_be[2*i+1];
            if (lo_h)      mdl[i][15:0] = h_wd[15:0];
            else if (lo_f) mdl[i][15:0] = f_wd[32*i +: 16];
            if (hi_f)      mdl[i][31:16] = f_wd[32*i+16 +: 16];
            else if (hi_h) mdl[i][31:16] = h_wd[31:16];
        end
        push_state(req);
    endtask

    task automatic host_wr(input int idx, input logic [1:0] be, input logic [31:0] d, input string req);
        step(1'b1, idx, be, d, '0, '0, '0, 1'b0, req);
    endtask

    task automatic fn_wr(input int i, input logic [1:0] be, input logic [31:0] d, input string req);
        logic [N-1:0]    m;
        logic [2*N-1:0]  b;
        logic [32*N-1:0] w;
        m = '0; b = '0; w = '0;
        m[i] = 1'b1; b[2*i +: 2] = be; w[32*i +: 32] = d;
        step(1'b0, 0, 2'b00, 32'h0, m, b, w, 1'b0, req);
    endtask

    task automatic host_rd(input int idx, input string req);
        host_idx = IDX_W'(idx);
        push(5, idx, mdl[idx], req);
        @(posedge clk);
        #1;
    endtask

    // Scoreboard monitor: compares queued expectations at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            while (sbq.size() > 0) begin
                item_t       it;
                logic [31:0] act;
                it = sbq.pop_front();
                case (it.kind)
                    0: act = fn_rdata[32*it.idx +: 32];
                    1: act = 32'(fn_irq);
                    2: act = 32'(host_irq);
                    3: act = 32'(to_fn_valid);
                    4: act = 32'(to_host_valid);
                    5: act = host_rdata;
                    6: act = 32'({to_fn_type[4*it.idx +: 4], to_fn_data[10*it.idx +: 10]});
                    default: act = 32'({to_host_type[4*it.idx +: 4], to_host_data[10*it.idx +: 10]});
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind %0d idx %0d actual %h expected %h",
                             it.req, it.kind, it.idx, act, it.exp);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            errors++;
            $display("FAIL watchdog expired actual %0d expected below 200000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; host_we = 1'b0; host_idx = '0; host_be = '0; host_wdata = '0;
        fn_we = '0; fn_be = '0; fn_wdata = '0;
        for (int i = 0; i < N; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        push_state("R1");
        @(posedge clk);
        #1;
        // R4 / R2: host posts into word 1; lines unchanged before the edge
        step(1'b1, 1, 2'b01, 32'h0000_0017, '0, '0, '0, 1'b1, "R4 R2");
        push_fields(1, "R7");
        // R5: function 1 acknowledges by clearing bit 0
        fn_wr(1, 2'b01, 32'h0000_0016, "R5");
        // R3: only port 2 is enabled; port 1 slot carries junk
        step(1'b0, 0, 2'b00, 32'h0, 4'b0100, 8'b0011_0000,
             {32'h0, 32'hAD6B_0000, 32'hFFFF_FFFF, 32'h0}, 1'b0, "R3");
        push_fields(2, "R7");
        // R6: origin flag clear on function 3 post
        fn_wr(3, 2'b10, 32'h0015_0000, "R6");
        push_fields(3, "R7");
        // R8: in-use markers in the opposite halves
        fn_wr(0, 2'b01, 32'h0000_5A5A, "R8");
        host_wr(1, 2'b10, 32'h5A5A_0000, "R8");
        // R9: host lower and function upper of word 0 together
        step(1'b1, 0, 2'b01, 32'h0000_0027, 4'b0001, 8'b0000_0010,
             {96'h0, 32'h000B_0000}, 1'b0, "R9");
        push_fields(0, "R9");
        // R10: same-half collisions on word 2
        step(1'b1, 2, 2'b01, 32'h0000_4443, 4'b0100, 8'b0001_0000,
             {32'h0, 32'h0000_9990, 64'h0}, 1'b0, "R10");
        step(1'b1, 2, 2'b10, 32'h7777_0000, 4'b0100, 8'b0010_0000,
             {32'h0, 32'h1235_0000, 64'h0}, 1'b0, "R10");
        // R2: no enables, then full write
        host_wr(3, 2'b00, 32'hFFFF_FFFF, "R2");
        host_wr(3, 2'b11, 32'h8001_C00F, "R2");
        push_fields(3, "R7");
        // R5: host acknowledges word 2
        host_wr(2, 2'b10, 32'h1234_0000, "R5");
        for (int i = 0; i < N; i++) host_rd(i, "R11");
        @(negedge clk);
        #1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule